// File: doc/BRIEF.md
# Sound Command Mailbox

This block passes single-byte commands from a main processor to a sound processor through a one-entry mailbox with a handshake flag. The main processor sits on a 16-bit register bus with byte-lane enables. It writes a command, polls a status register to learn whether the sound side has taken it, and drives the sound processor's reset through a control register bit.

The sound processor sees the latched command on a dedicated output. It also sees an interrupt line that rises when a fresh command lands. It answers with a one-cycle acknowledge strobe, which drops the interrupt and marks the mailbox as consumed. Reading the command has no side effect.

Register select on the main bus: 0 selects the command register, 1 selects the control register, 2 selects the status register. All state changes happen on the rising clock edge. The status read data is combinational from the current state.

Top module: `snd_cmd_mailbox`

## Requirements
- R1: After reset, the command output is 0x00, the interrupt is low, the sound reset output is high, and a status read returns 0x00FC.
- R2: A main write to select 0 with byte enable bit 0 set latches data bits 7:0 into the command on the clock edge. Data bits 15:8 are discarded.
- R3: A main write to select 0 with byte enable bit 0 clear leaves the command, the interrupt and the handshake flag unchanged.
- R4: Latching a command clears the handshake flag and raises the interrupt on the same clock edge.
- R5: When select is 2, the read data is 0x00FC while the handshake flag is set and 0x00FD while it is clear. For any other select, the read data is 0x0000.
- R6: A sound-side acknowledge strobe sets the handshake flag and lowers the interrupt. The command value is unchanged.
- R7: When a command latch and an acknowledge strobe fall in the same cycle, the latch wins: the flag ends clear and the interrupt ends high.
- R8: A main write to select 1 with data bit 1 equal to 0 drives the sound reset output high. With data bit 1 equal to 1, it drives the output low. Byte enables are not consulted for this register.
- R9: The command output is held steady across cycles in which no command latch occurs, whatever the sound side does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mainWr | input | 1 | Main bus write strobe |
| mainSel | input | 2 | Register select: 0 command, 1 control, 2 status |
| mainByteEn | input | 2 | Byte-lane enables; bit 0 is the low lane |
| mainWrData | input | 16 | Main bus write data |
| mainRdData | output | 16 | Main bus read data (status when select is 2) |
| sndAck | input | 1 | Sound-side acknowledge strobe |
| sndCmd | output | 8 | Latched command for the sound side |
| sndIrq | output | 1 | Interrupt toward the sound processor |
| sndReset | output | 1 | Reset output holding the sound processor |

## Verification
Every register result is due one clock edge after the stimulus that causes it: the command byte, the handshake flag, the interrupt and the reset output all update on the edge that samples the strobe. Status read data follows the current flag combinationally, within the same cycle. The bench drives each stimulus on a falling edge. It queues the expected port values at the following rising edge, and the monitor compares them one nanosecond later, while the stimulus is still held. Each queued item therefore describes the state just after exactly one edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;

  localparam logic [7:0] STAT_TAKEN   = 8'hFC;
  localparam logic [7:0] STAT_PENDING = 8'hFD;

  localparam int RESET_CTRL_BIT = 1;

  typedef struct packed {
    logic cmdLoad;
    logic ackSet;
    logic ctrlWrite;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             mainWr,
  input  logic [SEL_W-1:0] mainSel,
  input  logic [LANES-1:0] mainByteEn,
  input  logic             sndAck,
  output mboxStrobe_t      strobe
);
  logic lowLaneWr;

  always_comb begin
    lowLaneWr        = mainWr && (mainSel == SEL_CMD) && mainByteEn[0];
    strobe.cmdLoad   = lowLaneWr;
    // a fresh command overrides a coincident acknowledge
    strobe.ackSet    = sndAck && !lowLaneWr;
    strobe.ctrlWrite = mainWr && (mainSel == SEL_CTRL);
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strobe,
  input  logic [SEL_W-1:0]  mainSel,
  input  logic [DATA_W-1:0] mainWrData,
  output logic [DATA_W-1:0] mainRdData,
  output logic [CMD_W-1:0]  sndCmd,
  output logic              sndIrq,
  output logic              sndReset
);
  localparam int PAD_W = DATA_W - 8;

  logic [CMD_W-1:0] cmdReg;
  logic             ackReg;
  logic             irqReg;
  logic             rstReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      ackReg <= 1'b1;
      irqReg <= 1'b0;
      rstReg <= 1'b1;
    end else begin
      if (strobe.cmdLoad) begin
        cmdReg <= mainWrData[CMD_W-1:0];
        ackReg <= 1'b0;
        irqReg <= 1'b1;
      end else if (strobe.ackSet) begin
        ackReg <= 1'b1;
        irqReg <= 1'b0;
      end
      if (strobe.ctrlWrite)
        rstReg <= !mainWrData[RESET_CTRL_BIT];
    end
  end

  always_comb begin
    mainRdData = '0;
    if (mainSel == SEL_STAT)
      mainRdData = {{PAD_W{1'b0}}, (ackReg ? STAT_TAKEN : STAT_PENDING)};
  end

  assign sndCmd   = cmdReg;
  assign sndIrq   = irqReg;
  assign sndReset = rstReg;
endmodule

// File: rtl/snd_cmd_mailbox.sv
module snd_cmd_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mainWr,
  input  logic [SEL_W-1:0]  mainSel,
  input  logic [DATA_W/8-1:0] mainByteEn,
  input  logic [DATA_W-1:0] mainWrData,
  output logic [DATA_W-1:0] mainRdData,
  input  logic              sndAck,
  output logic [CMD_W-1:0]  sndCmd,
  output logic              sndIrq,
  output logic              sndReset
);
  localparam int LANES = DATA_W / 8;

  mboxStrobe_t strobe;

  mbox_ctrl #(.LANES(LANES)) uCtrl (
    .mainWr     (mainWr),
    .mainSel    (mainSel),
    .mainByteEn (mainByteEn),
    .sndAck     (sndAck),
    .strobe     (strobe)
  );

  mbox_datapath #(.DATA_W(DATA_W), .CMD_W(CMD_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .mainSel    (mainSel),
    .mainWrData (mainWrData),
    .mainRdData (mainRdData),
    .sndCmd     (sndCmd),
    .sndIrq     (sndIrq),
    .sndReset   (sndReset)
  );
endmodule

// File: rtl/snd_cmd_mailbox_chk.sv
module snd_cmd_mailbox_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                mainWr,
  input logic [SEL_W-1:0]    mainSel,
  input logic [DATA_W/8-1:0] mainByteEn,
  input logic [DATA_W-1:0]   mainWrData,
  input logic [DATA_W-1:0]   mainRdData,
  input logic                sndAck,
  input logic [CMD_W-1:0]    sndCmd,
  input logic                sndIrq,
  input logic                sndReset
);
  logic cmdWr;
  assign cmdWr = mainWr && (mainSel == SEL_CMD) && mainByteEn[0];

  assert_cmd_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> sndCmd == $past(mainWrData[CMD_W-1:0]));

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWr |=> $stable(sndCmd));

  assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> sndIrq);

  assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sndAck && !cmdWr) |=> !sndIrq);

  assert_status_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mainSel == SEL_STAT) |->
      mainRdData == {{(DATA_W-8){1'b0}}, (sndIrq ? STAT_PENDING : STAT_TAKEN)});

  assert_reset_ctrl_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mainWr && mainSel == SEL_CTRL) |=> sndReset == !$past(mainWrData[RESET_CTRL_BIT]));
endmodule

bind snd_cmd_mailbox snd_cmd_mailbox_chk #(.DATA_W(DATA_W), .CMD_W(CMD_W)) uChk (.*);

// File: tb/sim_snd_cmd_mailbox.sv
module sim_snd_cmd_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mainWr = 1'b0;
  logic [1:0]  mainSel = 2'd3;
  logic [1:0]  mainByteEn = 2'b00;
  logic [15:0] mainWrData = '0;
  logic [15:0] mainRdData;
  logic        sndAck = 1'b0;
  logic [7:0]  sndCmd;
  logic        sndIrq;
  logic        sndReset;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // expected: {rd[15:0], cmd[7:0], irq, rst}
  logic [25:0] expQ[$];
  string       tagQ[$];

  logic [7:0] mCmd = 8'h00;
  logic       mAck = 1'b1;
  logic       mRst = 1'b1;

  always #4 clk = ~clk;

  snd_cmd_mailbox u0 (.*);

  task automatic doOp(input logic wr, input logic [1:0] sel, input logic [1:0] be,
                      input logic [15:0] data, input logic ack, input string tag);
    logic [15:0] rd;
    @(negedge clk);
    mainWr = wr; mainSel = sel; mainByteEn = be; mainWrData = data; sndAck = ack;
    @(posedge clk);
    if (wr && sel == 2'd0 && be[0]) begin
      mCmd = data[7:0];
      mAck = 1'b0;
    end else if (ack) begin
      mAck = 1'b1;
    end
    if (wr && sel == 2'd1) mRst = !data[1];
    rd = (sel == 2'd2) ? (mAck ? 16'h00FC : 16'h00FD) : 16'h0000;
    expQ.push_back({rd, mCmd, !mAck, mRst});
    tagQ.push_back(tag);
    @(negedge clk);
    mainWr = 1'b0; sndAck = 1'b0; mainSel = 2'd3; mainByteEn = 2'b00;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [25:0] e;
        logic [25:0] a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = {mainRdData, sndCmd, sndIrq, sndReset};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual rd=%h cmd=%h irq=%b rst=%b expected rd=%h cmd=%h irq=%b rst=%b",
                   t, a[25:10], a[9:2], a[1], a[0], e[25:10], e[9:2], e[1], e[0]);
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        failures++;
        $display("FAIL watchdog actual cycles=%0d expected completion", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state with status read
    doOp(0, 2'd2, 2'b00, 16'h0000, 0, "R1 reset");
    // R8 release sound reset
    doOp(1, 2'd1, 2'b00, 16'h0002, 0, "R8 release");
    // R2 R4 latch, upper byte discarded
    doOp(1, 2'd0, 2'b01, 16'hAB5A, 0, "R2 R4 latch");
    // R5 pending status
    doOp(0, 2'd2, 2'b00, 16'h0000, 0, "R5 pending");
    // R6 acknowledge
    doOp(0, 2'd2, 2'b00, 16'h0000, 1, "R6 ack");
    // R9 idle cycles keep command
    doOp(0, 2'd0, 2'b00, 16'hFFFF, 0, "R9 hold");
    doOp(0, 2'd0, 2'b00, 16'h0000, 1, "R9 ack no change");
    // R3 high-lane-only write ignored
    doOp(1, 2'd0, 2'b10, 16'h1234, 0, "R3 upper lane");
    doOp(0, 2'd2, 2'b00, 16'h0000, 0, "R3 status after");
    // R2 both lanes
    doOp(1, 2'd0, 2'b11, 16'h00C3, 0, "R2 both lanes");
    // R7 collision
    doOp(0, 2'd0, 2'b00, 16'h0000, 1, "R6 ack again");
    doOp(1, 2'd0, 2'b01, 16'h0077, 1, "R7 collision");
    doOp(0, 2'd2, 2'b00, 16'h0000, 0, "R7 status after");
    // R8 assert reset, byte enables ignored
    doOp(1, 2'd1, 2'b00, 16'hFFFD, 0, "R8 assert");
    doOp(1, 2'd1, 2'b10, 16'h0002, 0, "R8 release again");
    // R5 other select reads zero
    doOp(0, 2'd1, 2'b00, 16'h0000, 0, "R5 other select");
    // R2 zero command
    doOp(1, 2'd0, 2'b01, 16'hFF00, 0, "R2 zero cmd");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule